// File: doc/BRIEF.md
# Carry-First Select Adder

This block adds two unsigned operands and an incoming carry bit. It has no clock and no storage. It does not build two full sum words and throw one away. Instead it prepares two candidate carry words from one shared layer of per-bit XOR and AND terms. One candidate assumes the incoming carry is 0 and the other assumes it is 1. The incoming carry then selects one candidate, and a single row of XOR gates turns the selected carry word into the one sum that the block produces.

The operand width is a parameter, with a minimum of 2. Each candidate chain has its starting carry tied to a constant, so the first stage of each chain is simpler than a general full-adder stage. The selector is one AND-OR gate per bit rather than a 2:1 multiplexer. This works because the assume-0 carry word never has a 1 where the assume-1 word has a 0. The block fits wherever a combinational add of two words plus a carry is needed. A typical use is as one section of a larger select-style adder, where its carry output feeds the next section.

Top module: `carry_first_adder`

## Requirements
- R1: For every pair of operands and either carry-in value, {carry_out, total} equals the full-precision value op_x + op_y + carry_in.
- R2: In every bit position, the assume-0 carry word is never 1 where the assume-1 carry word is 0.
- R3: When carry_in is 0, the selected carry word equals the assume-0 carry word, and total equals the low WIDTH bits of op_x + op_y.
- R4: When carry_in is 1, the selected carry word equals the assume-1 carry word, and total equals the low WIDTH bits of op_x + op_y + 1.
- R5: carry_out is the most significant bit of the selected carry word. It is 1 exactly when op_x + op_y + carry_in exceeds 2^WIDTH − 1.
- R6: Bit 0 of total equals op_x[0] XOR op_y[0] XOR carry_in.
- R7: A carry that enters at bit 0 travels through every position. For op_x all ones, op_y zero and carry_in 1, total is zero and carry_out is 1.
- R8: The block meets R1 at both WIDTH 8 and WIDTH 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | WIDTH | First operand |
| op_y | input | WIDTH | Second operand |
| carry_in | input | 1 | Incoming carry; selects the candidate carry word |
| total | output | WIDTH | Sum, low WIDTH bits |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The bench runs every operand pair and both carry-in values at width 8. This catches a swapped candidate selection, which would give an off-by-one sum whenever carry_in is set. It also catches a wrong constant start for either chain, which would corrupt bit 1 onward. Directed cases drive full-length propagation (all ones plus a carry in) and maximum overflow. A chain link that was broken or wired to the wrong neighbour would leave stray ones in the sum or a missing carry_out in those cases. Random vectors at width 32 show that the parameterised indexing holds at a wider size, where an off-by-one in the sum alignment would shift the carries one bit.

// File: rtl/carry_first_adder.sv
module carry_first_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_x,
  input  logic [WIDTH-1:0] op_y,
  input  logic             carry_in,
  output logic [WIDTH-1:0] total,
  output logic             carry_out
);

  logic [WIDTH-1:0] half_sum;
  logic [WIDTH-1:0] half_carry;
  logic [WIDTH-1:0] carry_if0;
  logic [WIDTH-1:0] carry_if1;
  logic [WIDTH-1:0] carry_sel;

  assign half_sum   = op_x ^ op_y;
  assign half_carry = op_x & op_y;

  // chain with its start carry tied to 0: bit 0 reduces to the AND term
  always_comb begin
    carry_if0[0] = half_carry[0];
    for (int i = 1; i < WIDTH; i++)
      carry_if0[i] = half_carry[i] | (half_sum[i] & carry_if0[i-1]);
  end

  // chain with its start carry tied to 1: bit 0 reduces to the OR of both terms
  always_comb begin
    carry_if1[0] = half_carry[0] | half_sum[0];
    for (int i = 1; i < WIDTH; i++)
      carry_if1[i] = half_carry[i] | (half_sum[i] & carry_if1[i-1]);
  end

  assign carry_sel = carry_if0 | ({WIDTH{carry_in}} & carry_if1);
  assign carry_out = carry_sel[WIDTH-1];
  assign total     = half_sum ^ {carry_sel[WIDTH-2:0], carry_in};

  always_comb begin
    AST_CARRY_DOMINANCE: assert ((carry_if0 & ~carry_if1) == '0); // R2
    if (!carry_in)
      AST_PICK_ZERO_WORD: assert (carry_sel == carry_if0); // R3
    if (carry_in)
      AST_PICK_ONE_WORD: assert (carry_sel == carry_if1); // R4
    AST_TOTAL_EXACT: assert ({carry_out, total} ==
                             ({1'b0, op_x} + {1'b0, op_y} + {{WIDTH{1'b0}}, carry_in})); // R1
    AST_LOW_BIT: assert (total[0] == (op_x[0] ^ op_y[0] ^ carry_in)); // R6
  end

endmodule

// File: tb/carry_first_adder_tb.sv
module carry_first_adder_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0]  nx, ny, nsum;
  logic        ncin, ncout;
  logic [31:0] wx, wy, wsum;
  logic        wcin, wcout;

  carry_first_adder #(.WIDTH(8)) u_dut (
    .op_x(nx), .op_y(ny), .carry_in(ncin), .total(nsum), .carry_out(ncout));

  carry_first_adder #(.WIDTH(32)) u_dut_wide (
    .op_x(wx), .op_y(wy), .carry_in(wcin), .total(wsum), .carry_out(wcout));

  typedef struct {
    bit          wide;
    logic [32:0] expv;
    string       tag;
  } item_t;

  item_t q[$];
  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  task automatic drive(input bit wide, input logic [31:0] x, input logic [31:0] y,
                       input logic c, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    it.wide = wide;
    it.tag  = tag;
    if (wide) begin
      wx = x; wy = y; wcin = c;
      it.expv = {1'b0, x} + {1'b0, y} + {32'd0, c};
    end else begin
      nx = x[7:0]; ny = y[7:0]; ncin = c;
      it.expv = {24'd0, {1'b0, x[7:0]} + {1'b0, y[7:0]} + {8'd0, c}};
    end
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [32:0] got;
        it  = q.pop_front();
        got = it.wide ? {wcout, wsum} : {24'd0, ncout, nsum};
        checks++;
        if (got !== it.expv) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, got, it.expv);
        end
      end
    end
  end

  initial begin
    nx = '0; ny = '0; ncin = 1'b0;
    wx = '0; wy = '0; wcin = 1'b0;
    // quiescent state: zero operands give zero outputs (R1)
    drive(1'b0, 32'd0, 32'd0, 1'b0, "R1 zero inputs");
    drive(1'b1, 32'd0, 32'd0, 1'b0, "R1 zero inputs wide");
    // full propagation (R7) and overflow on carry_out (R5)
    drive(1'b0, 32'hFF, 32'h00, 1'b1, "R7 ripple through narrow");
    drive(1'b1, 32'hFFFF_FFFF, 32'd0, 1'b1, "R7 ripple through wide");
    drive(1'b0, 32'hFF, 32'hFF, 1'b1, "R5 max overflow");
    drive(1'b0, 32'h80, 32'h80, 1'b0, "R5 top-bit carry");
    drive(1'b0, 32'h7F, 32'h80, 1'b0, "R5 no overflow edge");
    drive(1'b0, 32'h01, 32'h00, 1'b1, "R6 low bit with carry");
    drive(1'b0, 32'h01, 32'h01, 1'b1, "R6 low bit both set");
    drive(1'b0, 32'hAA, 32'h55, 1'b0, "R3 alternating no carry");
    drive(1'b0, 32'hAA, 32'h55, 1'b1, "R4 alternating with carry");
    // exhaustive sweep at width 8 (R1, R3, R4)
    for (int i = 0; i < 65536; i++) begin
      for (int c = 0; c < 2; c++) begin
        logic [31:0] xv, yv;
        xv = {24'd0, i[7:0]};
        yv = {24'd0, i[15:8]};
        drive(1'b0, xv, yv, c[0], c[0] ? "R4 sweep" : "R3 sweep");
      end
    end
    // random vectors at width 32 (R8)
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] xv, yv;
      xv = $urandom();
      yv = $urandom();
      drive(1'b1, xv, yv, k[0], "R8 wide random");
    end
    repeat (4) @(posedge clk);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 190000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule